// File: doc/BRIEF.md
# Segment-and-Page Address Translator

This block turns a 24-bit virtual address into a 24-bit real address. It walks two levels of tables held in memory. A table designator gives the origin and length of a segment table. The segment entry it selects points at a page table, and the page entry gives the page frame. An eight-entry fully associative translation cache sits in front of the walk, so a repeated translation needs no memory reads.

Two designators are configured, one for the primary address space and one for the secondary address space, and a select bit on each request picks one of them. Segment size (64 KiB or 1 MiB) and page size (2 KiB or 4 KiB) are chosen at run time. Table entries arrive through a single read port that uses a valid/ready handshake. The block handles one request at a time. It answers with either a real address or an exception code.

Top module: `seg_page_xlate`

## Requirements
- R1: With cfgSegLarge=0 the segment index is va[23:16], and with cfgSegLarge=1 it is va[23:20]. The page index is the bits between the segment index and the offset. The offset is va[10:0] when cfgPageLarge=0 and va[11:0] when cfgPageLarge=1. A successful translation returns code 0 with rspAddr = {frame, offset}, where the frame is the low 13 bits (2 KiB pages) or the low 12 bits (4 KiB pages) of the page entry.
- R2: A designator is {length[31:24], origin[23:0]}. If the segment index is greater than length, the block returns code 1 (segment exception) and makes no memory read. Every exception response carries rspAddr = 0.
- R3: A segment entry is {invalid[31], protect[30], common[29], ptLength[28:20], ptOrigin[19:0]}, and the page table starts at {ptOrigin, 4'h0}. If invalid is set, the block returns code 1 after exactly one memory read.
- R4: If the page index is greater than ptLength, the block returns code 2 (page exception) and reads no page entry.
- R5: A page entry is memRdata[15:0]: {invalid[15], reserved[14:13], frame[12:0]}. If invalid is set or reserved is nonzero, the block returns code 2.
- R6: A store (reqStore=1) to a segment whose protect bit is set returns code 3 (protection). A load from the same segment translates normally. The same rule applies on a cache hit.
- R7: reqSec=1 selects secDesig and reqSec=0 selects primDesig.
- R8: A translation that succeeded is cached. Repeating it returns the same result without any memory read.
- R9: A cache entry filled from a common segment hits under either designator. An entry from any other segment hits only under the designator whose origin filled it.
- R10: A one-cycle purge pulse invalidates every cache entry. The cycle after the pulse shows no hit.
- R11: Fills replace entries in round-robin order, and the order starts at entry 0 after reset or purge. After nine distinct fills, the first translation misses and the second one still hits.
- R12: reqReady is high only when the block is idle. It drops in the cycle after a request is accepted. rspValid is a single-cycle pulse, and memory reads happen only while a request is in flight.
- R13: The segment entry is read at origin + 4*segmentIndex and the page entry at pageTableStart + 2*pageIndex. memValid and memAddr hold steady until memReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSegLarge | input | 1 | 1: 1 MiB segments, 0: 64 KiB |
| cfgPageLarge | input | 1 | 1: 4 KiB pages, 0: 2 KiB |
| primDesig | input | 32 | Primary table designator |
| secDesig | input | 32 | Secondary table designator |
| purge | input | 1 | Invalidate the whole cache |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request accepted |
| reqVa | input | 24 | Virtual address |
| reqStore | input | 1 | Access is a store |
| reqSec | input | 1 | Use secondary designator |
| rspValid | output | 1 | Response pulse |
| rspAddr | output | 24 | Real address (0 on exception) |
| rspExc | output | 2 | 0 none, 1 segment, 2 page, 3 protection |
| memValid | output | 1 | Table read request |
| memReady | input | 1 | Read accepted, data valid |
| memAddr | output | 24 | Table entry address |
| memRdata | input | 32 | Table entry data |

## Verification
The assertions assume that the configuration inputs and both designators stay stable while a request is in flight. They also assume that the cache is purged whenever the segment or page size changes, because cache tags do not record the size choice. The bench changes configuration only while the block is idle and purges right after each change. Its memory model gives the common segment one page table that both address spaces share, so a hit through either designator returns the same frame as a walk would.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W    = 24;
  localparam int RA_W    = 24;
  localparam int DES_W   = 32;
  localparam int MEM_W   = 32;
  localparam int SIDX_W  = 8;
  localparam int PIDX_W  = 9;
  localparam int FRAME_W = 13;
  localparam int VPN_W   = 13;
  localparam int PTO_W   = RA_W - 4;
  localparam int SE_INV  = 31;
  localparam int SE_PROT = 30;
  localparam int SE_COM  = 29;
  localparam int PTE_INV = 15;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_SEG  = 2'd1,
    EXC_PAGE = 2'd2,
    EXC_PROT = 2'd3
  } exc_e;

  typedef struct packed {
    logic latchReq;
    logic latchSeg;
    logic latchPte;
    logic memSelPage;
    logic fill;
    logic setRes;
    logic useHit;
    exc_e exc;
  } ctl_t;

  typedef struct packed {
    logic hit;
    logic hitProtFault;
    logic segLenBad;
    logic segInvalid;
    logic pgLenBad;
    logic pteInvalid;
    logic walkProtFault;
  } stat_t;
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xlate_pkg::*;
#(
  parameter int N = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               purge,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [RA_W-1:0]    lkOrigin,
  output logic               hit,
  output logic [FRAME_W-1:0] hitFrame,
  output logic               hitProt,
  input  logic               fill,
  input  logic [VPN_W-1:0]   fVpn,
  input  logic [RA_W-1:0]    fOrigin,
  input  logic               fCommon,
  input  logic               fProt,
  input  logic [FRAME_W-1:0] fFrame
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]       vld, comm, prot, match;
  logic [VPN_W-1:0]   vpnArr   [N];
  logic [RA_W-1:0]    orgArr   [N];
  logic [FRAME_W-1:0] frameArr [N];
  logic [PTR_W-1:0]   ptr;

  generate
    for (genvar i = 0; i < N; i++) begin : g_match
      assign match[i] = vld[i] && (vpnArr[i] == lkVpn) &&
                        (comm[i] || (orgArr[i] == lkOrigin));
    end
  endgenerate

  always_comb begin
    hit      = 1'b0;
    hitFrame = '0;
    hitProt  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        hit      = 1'b1;
        hitFrame = frameArr[i];
        hitProt  = prot[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
      ptr <= '0;
    end else if (purge) begin
      vld <= '0;
      ptr <= '0;
    end else if (fill) begin
      for (int i = 0; i < N; i++)
        if (ptr == PTR_W'(i)) vld[i] <= 1'b1;
      ptr <= (ptr == PTR_W'(N - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill && !purge) begin
      for (int i = 0; i < N; i++) begin
        if (ptr == PTR_W'(i)) begin
          vpnArr[i]   <= fVpn;
          orgArr[i]   <= fOrigin;
          frameArr[i] <= fFrame;
          comm[i]     <= fCommon;
          prot[i]     <= fProt;
        end
      end
    end
  end
endmodule

// File: rtl/xlate_datapath.sv
module xlate_datapath
  import xlate_pkg::*;
#(
  parameter int CACHE_N = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_t             ctl,
  output stat_t            stat,
  input  logic             cfgSegLarge,
  input  logic             cfgPageLarge,
  input  logic [DES_W-1:0] primDesig,
  input  logic [DES_W-1:0] secDesig,
  input  logic [VA_W-1:0]  reqVa,
  input  logic             reqStore,
  input  logic             reqSec,
  input  logic             purge,
  input  logic [MEM_W-1:0] memRdata,
  output logic [RA_W-1:0]  memAddr,
  output logic [RA_W-1:0]  rspAddr,
  output logic [1:0]       rspExc
);
  logic [VA_W-1:0]    vaQ;
  logic               storeQ, secQ, segProtQ, segComQ;
  logic [PTO_W-1:0]   ptOrgQ;
  logic [FRAME_W-1:0] frameQ;
  logic [RA_W-1:0]    rspAddrQ;
  exc_e               rspExcQ;

  logic [DES_W-1:0]   desSel;
  logic [SIDX_W-1:0]  segIdx;
  logic [PIDX_W-1:0]  pgIdx;
  logic [VPN_W-1:0]   vpn;
  logic [RA_W-1:0]    segAddr, pgAddr, stOrg;
  logic [FRAME_W-1:0] hitFrame, resFrame;
  logic               hitProt;
  logic [RA_W-1:0]    realAddr;

  assign desSel = secQ ? secDesig : primDesig;
  assign stOrg  = desSel[RA_W-1:0];

  always_comb begin
    segIdx = cfgSegLarge ? {4'b0, vaQ[23:20]} : vaQ[23:16];
    unique case ({cfgSegLarge, cfgPageLarge})
      2'b11:   pgIdx = {1'b0, vaQ[19:12]};
      2'b10:   pgIdx = vaQ[19:11];
      2'b01:   pgIdx = {5'b0, vaQ[15:12]};
      default: pgIdx = {4'b0, vaQ[15:11]};
    endcase
    vpn = cfgPageLarge ? {1'b0, vaQ[23:12]} : vaQ[23:11];
  end

  assign segAddr = stOrg + RA_W'({segIdx, 2'b00});
  assign pgAddr  = {ptOrgQ, 4'h0} + RA_W'({pgIdx, 1'b0});
  assign memAddr = ctl.memSelPage ? pgAddr : segAddr;

  assign resFrame = ctl.useHit ? hitFrame : frameQ;
  assign realAddr = cfgPageLarge ? {resFrame[11:0], vaQ[11:0]}
                                 : {resFrame, vaQ[10:0]};

  xlate_tlb #(.N(CACHE_N)) u_tlb (
    .clk      (clk),
    .rstN     (rstN),
    .purge    (purge),
    .lkVpn    (vpn),
    .lkOrigin (stOrg),
    .hit      (stat.hit),
    .hitFrame (hitFrame),
    .hitProt  (hitProt),
    .fill     (ctl.fill),
    .fVpn     (vpn),
    .fOrigin  (stOrg),
    .fCommon  (segComQ),
    .fProt    (segProtQ),
    .fFrame   (frameQ)
  );

  assign stat.hitProtFault  = hitProt && storeQ;
  assign stat.segLenBad     = segIdx > desSel[DES_W-1:RA_W];
  assign stat.segInvalid    = memRdata[SE_INV];
  assign stat.pgLenBad      = pgIdx > memRdata[28:20];
  assign stat.pteInvalid    = memRdata[PTE_INV] || (memRdata[14:13] != 2'b00);
  assign stat.walkProtFault = segProtQ && storeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ      <= '0;
      storeQ   <= 1'b0;
      secQ     <= 1'b0;
      segProtQ <= 1'b0;
      segComQ  <= 1'b0;
      ptOrgQ   <= '0;
      frameQ   <= '0;
      rspAddrQ <= '0;
      rspExcQ  <= EXC_NONE;
    end else begin
      if (ctl.latchReq) begin
        vaQ    <= reqVa;
        storeQ <= reqStore;
        secQ   <= reqSec;
      end
      if (ctl.latchSeg) begin
        segProtQ <= memRdata[SE_PROT];
        segComQ  <= memRdata[SE_COM];
        ptOrgQ   <= memRdata[PTO_W-1:0];
      end
      if (ctl.latchPte) frameQ <= memRdata[FRAME_W-1:0];
      if (ctl.setRes) begin
        rspExcQ  <= ctl.exc;
        rspAddrQ <= (ctl.exc == EXC_NONE) ? realAddr : '0;
      end
    end
  end

  assign rspAddr = rspAddrQ;
  assign rspExc  = rspExcQ;
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqValid,
  output logic  reqReady,
  input  logic  memReady,
  output logic  memValid,
  output logic  rspValid,
  input  stat_t stat,
  output ctl_t  ctl
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_SEGRD, ST_PGRD, ST_FILL, ST_RESP
  } state_e;

  state_e state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    reqReady  = 1'b0;
    memValid  = 1'b0;
    rspValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          nextState    = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (stat.hit) begin
          ctl.setRes = 1'b1;
          ctl.useHit = 1'b1;
          ctl.exc    = stat.hitProtFault ? EXC_PROT : EXC_NONE;
          nextState  = ST_RESP;
        end else if (stat.segLenBad) begin
          ctl.setRes = 1'b1;
          ctl.exc    = EXC_SEG;
          nextState  = ST_RESP;
        end else begin
          nextState = ST_SEGRD;
        end
      end
      ST_SEGRD: begin
        memValid = 1'b1;
        if (memReady) begin
          if (stat.segInvalid) begin
            ctl.setRes = 1'b1;
            ctl.exc    = EXC_SEG;
            nextState  = ST_RESP;
          end else if (stat.pgLenBad) begin
            ctl.setRes = 1'b1;
            ctl.exc    = EXC_PAGE;
            nextState  = ST_RESP;
          end else begin
            ctl.latchSeg = 1'b1;
            nextState    = ST_PGRD;
          end
        end
      end
      ST_PGRD: begin
        memValid       = 1'b1;
        ctl.memSelPage = 1'b1;
        if (memReady) begin
          if (stat.pteInvalid) begin
            ctl.setRes = 1'b1;
            ctl.exc    = EXC_PAGE;
            nextState  = ST_RESP;
          end else begin
            ctl.latchPte = 1'b1;
            nextState    = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        ctl.fill   = 1'b1;
        ctl.setRes = 1'b1;
        ctl.exc    = stat.walkProtFault ? EXC_PROT : EXC_NONE;
        nextState  = ST_RESP;
      end
      ST_RESP: begin
        rspValid  = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import xlate_pkg::*;
#(
  parameter int CACHE_N = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgSegLarge,
  input  logic             cfgPageLarge,
  input  logic [DES_W-1:0] primDesig,
  input  logic [DES_W-1:0] secDesig,
  input  logic             purge,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVa,
  input  logic             reqStore,
  input  logic             reqSec,
  output logic             rspValid,
  output logic [RA_W-1:0]  rspAddr,
  output logic [1:0]       rspExc,
  output logic             memValid,
  input  logic             memReady,
  output logic [RA_W-1:0]  memAddr,
  input  logic [MEM_W-1:0] memRdata
);
  ctl_t  ctl;
  stat_t stat;

  xlate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .memReady (memReady),
    .memValid (memValid),
    .rspValid (rspValid),
    .stat     (stat),
    .ctl      (ctl)
  );

  xlate_datapath #(.CACHE_N(CACHE_N)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .stat         (stat),
    .cfgSegLarge  (cfgSegLarge),
    .cfgPageLarge (cfgPageLarge),
    .primDesig    (primDesig),
    .secDesig     (secDesig),
    .reqVa        (reqVa),
    .reqStore     (reqStore),
    .reqSec       (reqSec),
    .purge        (purge),
    .memRdata     (memRdata),
    .memAddr      (memAddr),
    .rspAddr      (rspAddr),
    .rspExc       (rspExc)
  );
endmodule

// File: rtl/xlate_checker.sv
module xlate_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        rspValid,
  input logic [1:0]  rspExc,
  input logic [23:0] rspAddr,
  input logic        memValid,
  input logic        memReady,
  input logic [23:0] memAddr,
  input logic        purge,
  input logic        cacheHit
);
  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_accept_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  assert_mem_in_flight_R12: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !reqReady);

  assert_mem_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr));

  assert_exc_zero_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspExc != 2'd0) |-> rspAddr == 24'h0);

  assert_purge_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    purge |=> !cacheHit);
endmodule

bind seg_page_xlate xlate_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .rspExc   (rspExc),
  .rspAddr  (rspAddr),
  .memValid (memValid),
  .memReady (memReady),
  .memAddr  (memAddr),
  .purge    (purge),
  .cacheHit (stat.hit)
);

// File: tb/sim_seg_page_xlate.sv
module sim_seg_page_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgSegLarge = 1'b0, cfgPageLarge = 1'b0;
  logic [31:0] primDesig = {8'd12, 24'h100000};
  logic [31:0] secDesig  = {8'd15, 24'h200000};
  logic        purge = 1'b0, reqValid = 1'b0, reqStore = 1'b0, reqSec = 1'b0;
  logic [23:0] reqVa = '0;
  logic        reqReady, rspValid, memValid;
  logic        memReady = 1'b0;
  logic [23:0] rspAddr, memAddr;
  logic [1:0]  rspExc;
  logic [31:0] memRdata;

  int tests = 0, fails = 0, readCnt = 0, cyc = 0;
  logic busyAfterAccept;

  always #2 clk = ~clk;

  seg_page_xlate u0 (.*);

  function automatic logic [31:0] segEnt(int t, int s);
    logic [31:0] e;
    int tt = (s == 2) ? 0 : t;
    int base = 'h400000 + tt * 'h10000 + s * 'h400;
    e[31]    = (s == 7);
    e[30]    = ((s % 4) == 1);
    e[29]    = (s == 2);
    e[28:20] = 9'((s == 5) ? 2 : 300);
    e[19:0]  = 20'(base >> 4);
    return e;
  endfunction

  function automatic logic [15:0] pteOf(int t, int s, int p);
    return {p == 3, 2'b00, 13'((t * 7 + s * 13 + p * 5) % 8192)};
  endfunction

  function automatic logic [31:0] memData(logic [23:0] a);
    int off, t, s, p;
    if (a[23:20] == 4'h1 || a[23:20] == 4'h2)
      return segEnt(int'(a[23:20]) - 1, int'(a[19:0]) >> 2);
    if (a >= 24'h400000) begin
      off = int'(a) - 'h400000;
      t = off >> 16; s = (off >> 10) & 63; p = (off >> 1) & 511;
      return {16'h0, pteOf(t, s, p)};
    end
    return 32'h0;
  endfunction

  assign memRdata = memData(memAddr);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    memReady <= ((cyc % 3) != 1);
  end
  always @(posedge clk) if (memValid && memReady) readCnt <= readCnt + 1;

  function automatic logic [25:0] expectOf(logic [23:0] va, bit st, bit sc, bit segL, bit pageL);
    int sIdx, pIdx, stl;
    logic [31:0] e; logic [15:0] pe;
    sIdx = segL ? int'(va[23:20]) : int'(va[23:16]);
    stl = sc ? 15 : 12;
    if (sIdx > stl) return {2'd1, 24'h0};
    e = segEnt(sc, sIdx);
    if (e[31]) return {2'd1, 24'h0};
    pIdx = segL ? (pageL ? int'(va[19:12]) : int'(va[19:11]))
                : (pageL ? int'(va[15:12]) : int'(va[15:11]));
    if (pIdx > int'(e[28:20])) return {2'd2, 24'h0};
    pe = pteOf((sIdx == 2) ? 0 : int'(sc), sIdx, pIdx);
    if (pe[15]) return {2'd2, 24'h0};
    if (e[30] && st) return {2'd3, 24'h0};
    return {2'd0, pageL ? {pe[11:0], va[11:0]} : {pe[12:0], va[10:0]}};
  endfunction

  function automatic logic [23:0] makeVa(int s, int p, bit segL, bit pageL);
    int sh = pageL ? 12 : 11;
    int off = (s * 37 + p * 11 + 5) & ((1 << sh) - 1);
    return 24'((s << (segL ? 20 : 16)) | (p << sh) | off);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReq(input logic [23:0] va, input bit st, input bit sc,
                       output logic [25:0] res, output int reads);
    int r0, n;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    r0 = readCnt;
    reqVa = va; reqStore = st; reqSec = sc; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    busyAfterAccept = reqReady;
    n = 0;
    while (!rspValid && n < 200) begin @(negedge clk); n++; end
    if (!rspValid) begin
      check(1'b0, "R12 response timeout", 0, 1);
      res = '1;
    end else res = {rspExc, rspAddr};
    reads = readCnt - r0;
  endtask

  task automatic doPurge();
    @(negedge clk); purge = 1'b1;
    @(negedge clk); purge = 1'b0;
  endtask

  task automatic setCfg(bit segL, bit pageL);
    @(negedge clk); cfgSegLarge = segL; cfgPageLarge = pageL;
    doPurge();
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [25:0] r, e, r2;
    int rd, rd2;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "reset R12 reqReady", 32'(reqReady), 1);
    check(rspValid == 1'b0, "reset R12 rspValid", 32'(rspValid), 0);
    check(memValid == 1'b0, "reset R12 memValid", 32'(memValid), 0);
    rstN = 1'b1;

    // R1 R2 R3 R4 R5 R6 R7 R13: sweep over all four size choices
    for (int c = 0; c < 4; c++) begin
      bit segL = c[1], pageL = c[0];
      int pMax = segL ? (pageL ? 255 : 511) : (pageL ? 15 : 31);
      int pList[5] = '{0, 1, 3, 4, pMax};
      setCfg(segL, pageL);
      for (int s = 0; s < 16; s++)
        for (int pi = 0; pi < 5; pi++)
          for (int k = 0; k < 4; k++) begin
            logic [23:0] va = makeVa(s, pList[pi], segL, pageL);
            e = expectOf(va, k[0], k[1], segL, pageL);
            doReq(va, k[0], k[1], r, rd);
            check(r == e, "R1/R7 sweep translation", 32'(r), 32'(e));
          end
    end

    setCfg(1'b1, 1'b1);
    // R2: length violation, no memory read
    doReq(makeVa(14, 0, 1, 1), 0, 0, r, rd);
    check(r == {2'd1, 24'h0}, "R2 seg length exc", 32'(r), 32'h1000000);
    check(rd == 0, "R2 no read", rd, 0);
    // R3: invalid segment, one read
    doReq(makeVa(7, 0, 1, 1), 0, 0, r, rd);
    check(r[25:24] == 2'd1 && rd == 1, "R3 seg invalid", 32'(rd), 1);
    // R4: page length, one read
    doReq(makeVa(5, 4, 1, 1), 0, 0, r, rd);
    check(r[25:24] == 2'd2 && rd == 1, "R4 page length", 32'(rd), 1);
    // R5: invalid page entry, two reads
    doReq(makeVa(0, 3, 1, 1), 0, 0, r, rd);
    check(r[25:24] == 2'd2 && rd == 2, "R5 pte invalid", 32'(rd), 2);
    // R8 + R12
    doPurge();
    doReq(makeVa(4, 6, 1, 1), 0, 0, r, rd);
    check(busyAfterAccept == 1'b0, "R12 busy after accept", 32'(busyAfterAccept), 0);
    check(rd == 2, "R8 first walk reads", rd, 2);
    doReq(makeVa(4, 6, 1, 1), 0, 0, r2, rd2);
    check(r2 == r && rd2 == 0, "R8 hit no reads", 32'(rd2), 0);
    // R6 on a hit
    doReq(makeVa(1, 6, 1, 1), 0, 0, r, rd);
    doReq(makeVa(1, 6, 1, 1), 1, 0, r, rd);
    check(r == {2'd3, 24'h0} && rd == 0, "R6 protect on hit", 32'(r), 32'h3000000);
    // R9 common vs private
    doReq(makeVa(2, 9, 1, 1), 0, 0, r, rd);
    doReq(makeVa(2, 9, 1, 1), 0, 1, r2, rd2);
    check(r2 == r && rd2 == 0, "R9 common hits other space", 32'(rd2), 0);
    doReq(makeVa(4, 6, 1, 1), 0, 1, r2, rd2);
    e = expectOf(makeVa(4, 6, 1, 1), 0, 1, 1, 1);
    check(r2 == e && rd2 == 2, "R9 private walks other space", 32'(r2), 32'(e));
    // R10 purge
    doPurge();
    doReq(makeVa(4, 6, 1, 1), 0, 0, r, rd);
    check(rd == 2, "R10 purge forces walk", rd, 2);
    // R11 round robin
    doPurge();
    for (int p = 4; p < 13; p++) doReq(makeVa(0, p, 1, 1), 0, 0, r, rd);
    doReq(makeVa(0, 5, 1, 1), 0, 0, r, rd);
    check(rd == 0, "R11 second fill survives", rd, 0);
    doReq(makeVa(0, 4, 1, 1), 0, 0, r, rd);
    check(rd == 2, "R11 first fill evicted", rd, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule